// File: doc/BRIEF.md
# Capture/Compare Timer with Split Mode

This block is a free-running up-counter that a single configuration word turns into one of several timing functions. In timer operation it advances on a prescaled tick and either toggles an output when it meets a compare value or, when an edge of an external pin is selected, snapshots its count into a capture register and restarts from a reload value. In counter operation it counts the selected pin edges instead of ticks. The counter wraps from all-ones to the reload value and raises an overflow flag.

The count register can also be split into two independent halves. The upper half keeps the whole timer, counter and capture behaviour. The lower half always runs as a compare timer on the internal prescaled tick, using the lower halves of the reload and compare inputs. The tick source is either the system clock or a slow alternate clock. The slow clock is never used as a clock. It is synchronised, and its rising edges drive the prescaler as single-cycle enables.

Sticky interrupt flags are set by hardware and cleared by a per-flag clear strobe. The prescaler restarts whenever the configuration word changes.

Top module: `capcmp_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `count_o`, `cap_o`, `cmp_o`, `cmp_lo_o` and `flags_o` all become zero.
- R2: The pin edge field `cfg_i[1:0]` selects the pin event from the synchronised pin: 01 rising, 10 falling, 11 both, 00 none. The pin is seen three clock edges after it changes, counted as two synchroniser stages plus one history stage.
- R3: Compare mode is `cfg_i[2]`=0 with `cfg_i[1:0]`=00. Each tick advances the count by one. When the advanced value equals `compare_i`, `cmp_o` toggles and flag bit 1 is set.
- R4: A tick or counted edge taken at all-ones loads `reload_i` instead of wrapping to zero, and sets flag bit 2.
- R5: Capture mode is `cfg_i[2]`=0 with a nonzero edge field. On a selected pin event, `cap_o` takes the current count, the count loads `reload_i` and flag bit 0 is set, all at one edge. A capture takes priority over a tick at the same edge.
- R6: Counter mode is `cfg_i[2]`=1. It advances once per selected pin event and ignores ticks. With edge field 00 the count is frozen.
- R7: Split mode is `cfg_i[3]`=1. The upper half applies R3 to R6 at half width, using the upper halves of `reload_i` and `compare_i`, and captures into the upper half of `cap_o` with the lower half zero. The lower half always runs R3/R4 on ticks, using the lower halves, `cmp_lo_o`, and flag bits 3 (compare) and 4 (overflow). `cmp_lo_o` never changes in 16-bit mode.
- R8: The divide field `cfg_i[6:4]`=N gives one tick per 2^N tick-source pulses.
- R9: With `cfg_i[7]`=1 the tick source is the rising edges of `alt_clk_i` after a two-flop synchroniser. Otherwise it is every system clock cycle.
- R10: At the first clock edge where `cfg_i` differs from its value at the previous edge, the prescaler restarts and produces no tick. The next tick comes a full 2^N source pulses later.
- R11: Each bit of `flags_o` stays set until the matching bit of `clr_i` is high at an edge. A set at the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_i | input | 8 | Configuration word: [1:0] edge, [2] counter, [3] split, [6:4] divide, [7] alternate source |
| pin_i | input | 1 | External event pin (asynchronous) |
| alt_clk_i | input | 1 | Slow alternate tick source (asynchronous) |
| reload_i | input | CNT_W | Reload value |
| compare_i | input | CNT_W | Compare value |
| clr_i | input | 5 | Per-flag clear strobes |
| count_o | output | CNT_W | Current count |
| cap_o | output | CNT_W | Captured count |
| cmp_o | output | 1 | Compare toggle output (16-bit or upper half) |
| cmp_lo_o | output | 1 | Compare toggle output of the lower half |
| flags_o | output | 5 | Sticky flags: 0 capture, 1 compare, 2 overflow, 3 lower compare, 4 lower overflow |

## Verification
The bench builds the block with its defaults, a 16-bit count and a three-bit divide field. This keeps a full 16-bit wrap within about 65 thousand cycles, so the reload on overflow and a second pass through the compare value can be observed. The /128 divide, the largest ratio, is covered in a few hundred cycles. The 8-bit halves wrap more than once in a short run, which exposes the two halves' separate reload and compare bytes.

// File: rtl/cct_pkg.sv
// Shared types for the capture/compare timer.
// Assumes: configuration word layout is fixed by cct_cfg_t below.
package cct_pkg;

    parameter int DIV_W = 3;

    typedef struct packed {
        logic             alt;    // tick source: alternate clock
        logic [DIV_W-1:0] div;    // prescale exponent
        logic             split;  // two independent halves
        logic             ctr;    // count pin events
        logic [1:0]       esel;   // pin edge select
    } cct_cfg_t;

    localparam int CFG_W    = $bits(cct_cfg_t);
    localparam int NFLAGS   = 5;
    localparam int FL_CAP   = 0;
    localparam int FL_CMP   = 1;
    localparam int FL_OVF   = 2;
    localparam int FL_CMPLO = 3;
    localparam int FL_OVFLO = 4;

endpackage

// File: rtl/cct_sync.sv
// Two-flop synchroniser with one history stage.
// Assumes: async_i is slower than clk; the caller derives edges from lvl_o/prev_o.
module cct_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o,
    output logic prev_o
);

    logic meta_q;
    logic lvl_q;
    logic prev_q;

    // Shift the input through the synchroniser and keep one old sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            lvl_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl_o  = lvl_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/cct_presc.sv
// Power-of-two prescaler producing a single-cycle tick.
// Assumes: src_en_i marks one tick-source pulse; restart_i clears the count
// and suppresses the tick in that cycle.
module cct_presc #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             src_en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    localparam int PW = (1 << DIV_W) - 1;

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] lim;
    logic          wrap;

    // Terminal count for the selected ratio; 2^N-1 in PW bits.
    always_comb begin
        lim  = (PW'(1) << div_i) - PW'(1);
        wrap = (cnt_q == lim);
    end

    assign tick_o = !restart_i && src_en_i && wrap;

    // Advance on each source pulse, restart on terminal count or config change.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q <= '0;
        end else if (src_en_i) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cct_core.sv
// Count, capture and compare datapath for 16-bit or split operation.
// Assumes: tick_i and pin edges are single-cycle enables in the clk domain;
// CNT_W is even.
module cct_core #(
    parameter int CNT_W  = 16,
    parameter int NFLAGS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        esel_i,
    input  logic              ctr_i,
    input  logic              split_i,
    input  logic              tick_i,
    input  logic              pin_lvl_i,
    input  logic              pin_prev_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [CNT_W-1:0]  compare_i,
    input  logic [NFLAGS-1:0] clr_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  cap_o,
    output logic              cmp_o,
    output logic              cmp_lo_o,
    output logic [NFLAGS-1:0] flags_o
);

    import cct_pkg::*;

    localparam int HW = CNT_W / 2;

    logic [CNT_W-1:0]  cnt_q, cnt_d, cap_q, cap_d;
    logic              cmp_q, cmp_d, cmplo_q, cmplo_d;
    logic [NFLAGS-1:0] flg_q, set;
    logic [HW-1:0]     hi_d, lo_d;
    logic              rise, fall, pin_evt;
    logic              cap_mode, cmp_mode, cnt_mode, step;

    // Decode pin edges and the operating mode of the main counter.
    always_comb begin
        rise     = pin_lvl_i && !pin_prev_i;
        fall     = !pin_lvl_i && pin_prev_i;
        pin_evt  = (esel_i[0] && rise) || (esel_i[1] && fall);
        cap_mode = !ctr_i && (esel_i != 2'b00);
        cmp_mode = !ctr_i && (esel_i == 2'b00);
        cnt_mode = ctr_i && (esel_i != 2'b00);
        step     = cnt_mode ? pin_evt : (!ctr_i && tick_i);
    end

    // Next count, capture, compare outputs and flag sets.
    always_comb begin
        cnt_d   = cnt_q;
        cap_d   = cap_q;
        cmp_d   = cmp_q;
        cmplo_d = cmplo_q;
        set     = '0;
        hi_d    = cnt_q[CNT_W-1:HW];
        lo_d    = cnt_q[HW-1:0];
        if (!split_i) begin
            if (cap_mode && pin_evt) begin
                cap_d       = cnt_q;
                cnt_d       = reload_i;
                set[FL_CAP] = 1'b1;
            end else if (step) begin
                if (&cnt_q) begin
                    cnt_d       = reload_i;
                    set[FL_OVF] = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
                if (cmp_mode && (cnt_d == compare_i)) begin
                    cmp_d       = !cmp_q;
                    set[FL_CMP] = 1'b1;
                end
            end
        end else begin
            // Upper half: full feature set at half width.
            if (cap_mode && pin_evt) begin
                cap_d       = {cnt_q[CNT_W-1:HW], {HW{1'b0}}};
                hi_d        = reload_i[CNT_W-1:HW];
                set[FL_CAP] = 1'b1;
            end else if (step) begin
                if (&cnt_q[CNT_W-1:HW]) begin
                    hi_d        = reload_i[CNT_W-1:HW];
                    set[FL_OVF] = 1'b1;
                end else begin
                    hi_d = cnt_q[CNT_W-1:HW] + 1'b1;
                end
                if (cmp_mode && (hi_d == compare_i[CNT_W-1:HW])) begin
                    cmp_d       = !cmp_q;
                    set[FL_CMP] = 1'b1;
                end
            end
            // Lower half: always compare timer on the prescaled tick.
            if (tick_i) begin
                if (&cnt_q[HW-1:0]) begin
                    lo_d          = reload_i[HW-1:0];
                    set[FL_OVFLO] = 1'b1;
                end else begin
                    lo_d = cnt_q[HW-1:0] + 1'b1;
                end
                if (lo_d == compare_i[HW-1:0]) begin
                    cmplo_d         = !cmplo_q;
                    set[FL_CMPLO]   = 1'b1;
                end
            end
            cnt_d = {hi_d, lo_d};
        end
    end

    // State registers; flag sets win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cap_q   <= '0;
            cmp_q   <= 1'b0;
            cmplo_q <= 1'b0;
            flg_q   <= '0;
        end else begin
            cnt_q   <= cnt_d;
            cap_q   <= cap_d;
            cmp_q   <= cmp_d;
            cmplo_q <= cmplo_d;
            flg_q   <= (flg_q & ~clr_i) | set;
        end
    end

    assign count_o  = cnt_q;
    assign cap_o    = cap_q;
    assign cmp_o    = cmp_q;
    assign cmp_lo_o = cmplo_q;
    assign flags_o  = flg_q;

endmodule

// File: rtl/capcmp_timer.sv
// Capture/compare timer top: synchronisers, prescaler and count datapath.
// Assumes: pin_i and alt_clk_i are asynchronous and at most clk/4;
// cfg_i layout follows cct_pkg::cct_cfg_t.
module capcmp_timer
    import cct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic              pin_i,
    input  logic              alt_clk_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [CNT_W-1:0]  compare_i,
    input  logic [NFLAGS-1:0] clr_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  cap_o,
    output logic              cmp_o,
    output logic              cmp_lo_o,
    output logic [NFLAGS-1:0] flags_o
);

    cct_cfg_t cfg, cfg_q;
    logic     cfg_chg;
    logic     pin_lvl, pin_prev, alt_lvl, alt_prev;
    logic     src_en, tick;

    assign cfg     = cct_cfg_t'(cfg_i);
    assign cfg_chg = (cfg != cfg_q);
    assign src_en  = cfg.alt ? (alt_lvl && !alt_prev) : 1'b1;

    // Remember the configuration seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg;
        end
    end

    cct_sync i_pin_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .lvl_o   (pin_lvl),
        .prev_o  (pin_prev)
    );

    cct_sync i_alt_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (alt_clk_i),
        .lvl_o   (alt_lvl),
        .prev_o  (alt_prev)
    );

    cct_presc #(.DIV_W(DIV_W)) i_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (cfg_chg),
        .src_en_i  (src_en),
        .div_i     (cfg.div),
        .tick_o    (tick)
    );

    cct_core #(.CNT_W(CNT_W), .NFLAGS(NFLAGS)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .esel_i     (cfg.esel),
        .ctr_i      (cfg.ctr),
        .split_i    (cfg.split),
        .tick_i     (tick),
        .pin_lvl_i  (pin_lvl),
        .pin_prev_i (pin_prev),
        .reload_i   (reload_i),
        .compare_i  (compare_i),
        .clr_i      (clr_i),
        .count_o    (count_o),
        .cap_o      (cap_o),
        .cmp_o      (cmp_o),
        .cmp_lo_o   (cmp_lo_o),
        .flags_o    (flags_o)
    );

endmodule

// File: rtl/cct_timer_chk.sv
// Port-level property checker for capcmp_timer, attached by bind.
// Assumes: same parameters as the bound instance.
module cct_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       cfg_i,
    input logic [CNT_W-1:0] reload_i,
    input logic [4:0]       clr_i,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] cap_o,
    input logic             cmp_o,
    input logic             cmp_lo_o,
    input logic [4:0]       flags_o
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && cap_o == '0 && flags_o == '0 && !cmp_o && !cmp_lo_o))
        else $error("p_reset_clear_r1");

    p_cmp_toggle_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_o) |-> flags_o[1])
        else $error("p_cmp_toggle_flag_r3");

    p_capture_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flags_o[0]) && !$past(cfg_i[3])) |-> (count_o == $past(reload_i)))
        else $error("p_capture_reload_r5");

    p_count_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[2] && cfg_i[1:0] == 2'b00) |=> $stable(count_o))
        else $error("p_count_frozen_r6");

    p_lo_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i[3] |=> $stable(cmp_lo_o))
        else $error("p_lo_idle_r7");

    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & $past(flags_o & ~clr_i)) == $past(flags_o & ~clr_i)))
        else $error("p_flag_hold_r11");

endmodule

bind capcmp_timer cct_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_i    (cfg_i),
    .reload_i (reload_i),
    .clr_i    (clr_i),
    .count_o  (count_o),
    .cap_o    (cap_o),
    .cmp_o    (cmp_o),
    .cmp_lo_o (cmp_lo_o),
    .flags_o  (flags_o)
);

// File: tb/test_capcmp_timer.sv
module test_capcmp_timer;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;

    typedef struct packed {
        logic [7:0]  cfg;
        logic [15:0] rel;
        logic [15:0] cmp;
        logic [31:0] ncyc;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 16'h0000, 16'h0005, 32'd10},
        '{8'h20, 16'h0000, 16'h0003, 32'd21},
        '{8'h70, 16'h0000, 16'h0001, 32'd260},
        '{8'h08, 16'h10F0, 16'h0420, 32'd301},
        '{8'h00, 16'hFF00, 16'hFF10, 32'd65576}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   cfg_i = '0;
    logic         pin_i = 1'b0;
    logic         alt_clk_i = 1'b0;
    logic [W-1:0] reload_i = '0;
    logic [W-1:0] compare_i = '0;
    logic [4:0]   clr_i = '0;
    logic [W-1:0] count_o, cap_o;
    logic         cmp_o, cmp_lo_o;
    logic [4:0]   flags_o;

    int n_run  = 0;
    int n_fail = 0;

    capcmp_timer #(.CNT_W(W)) i_capcmp_timer (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .pin_i(pin_i),
        .alt_clk_i(alt_clk_i), .reload_i(reload_i), .compare_i(compare_i),
        .clr_i(clr_i), .count_o(count_o), .cap_o(cap_o), .cmp_o(cmp_o),
        .cmp_lo_o(cmp_lo_o), .flags_o(flags_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance n clock edges, returning at the following falling edge.
    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic [7:0] c, input logic [15:0] r, input logic [15:0] k);
        rst_n = 1'b0; cfg_i = c; reload_i = r; compare_i = k;
        pin_i = 1'b0; alt_clk_i = 1'b0; clr_i = '0;
        step(2);
        rst_n = 1'b1;
    endtask

    // Independent up-counter model: wrap at all-ones to reload.
    function automatic void model(input int ticks, input int w, input int rel, input int k,
                                  output int cnt, output int tog, output int ovf, output int hit);
        int mx = (1 << w) - 1;
        cnt = 0; tog = 0; ovf = 0; hit = 0;
        for (int t = 0; t < ticks; t++) begin
            if (cnt == mx) begin cnt = rel; ovf = 1; end
            else cnt = cnt + 1;
            if (cnt == k) begin tog = tog ^ 1; hit = 1; end
        end
    endfunction

    initial begin
        int c, e_cnt, e_tog, e_ovf, e_hit, l_cnt, l_tog, l_ovf, l_hit, ticks;
        @(negedge clk);

        // Table of compare-mode runs: R3, R4, R7, R8.
        for (int v = 0; v < NV; v++) begin
            do_reset(VECS[v].cfg, VECS[v].rel, VECS[v].cmp);
            if (v == 0) begin
                check("R1 count", int'(count_o), 0);
                check("R1 capture", int'(cap_o), 0);
                check("R1 flags", int'(flags_o), 0);
                check("R1 compare outs", int'({cmp_o, cmp_lo_o}), 0);
            end
            step(int'(VECS[v].ncyc));
            ticks = (int'(VECS[v].ncyc) - ((VECS[v].cfg != 0) ? 1 : 0)) >> VECS[v].cfg[6:4];
            if (!VECS[v].cfg[3]) begin
                model(ticks, 16, int'(VECS[v].rel), int'(VECS[v].cmp), e_cnt, e_tog, e_ovf, e_hit);
                check("R3/R8 count", int'(count_o), e_cnt);
                check("R3 cmp_o", int'(cmp_o), e_tog);
                check("R3 cmp flag", int'(flags_o[1]), e_hit);
                check("R4 ovf flag", int'(flags_o[2]), e_ovf);
            end else begin
                model(ticks, 8, int'(VECS[v].rel[15:8]), int'(VECS[v].cmp[15:8]), e_cnt, e_tog, e_ovf, e_hit);
                model(ticks, 8, int'(VECS[v].rel[7:0]), int'(VECS[v].cmp[7:0]), l_cnt, l_tog, l_ovf, l_hit);
                check("R7 split count", int'(count_o), (e_cnt << 8) | l_cnt);
                check("R7 cmp outs", int'({cmp_o, cmp_lo_o}), (e_tog << 1) | l_tog);
                check("R7/R4 flags", int'(flags_o[4:1]), (l_ovf << 3) | (l_hit << 2) | (e_ovf << 1) | e_hit);
            end
        end

        // R5/R2: capture on rising edge, falling ignored with edge field 01.
        do_reset(8'h01, 16'h0100, 16'h0000);
        step(10);
        pin_i = 1'b1;
        step(2);
        c = int'(count_o);
        step(1);
        check("R5 capture value", int'(cap_o), c);
        check("R5 reload on capture", int'(count_o), 16'h0100);
        check("R5 capture flag", int'(flags_o[0]), 1);
        step(5);
        check("R11 flag sticky", int'(flags_o[0]), 1);
        pin_i = 1'b0;
        step(5);
        check("R2 falling ignored", int'(cap_o), c);
        clr_i = 5'b00001;
        step(1);
        clr_i = '0;
        check("R11 flag cleared", int'(flags_o[0]), 0);

        // R2: falling-edge capture.
        do_reset(8'h02, 16'h0000, 16'h0000);
        pin_i = 1'b1;
        step(6);
        check("R2 rising ignored for 10", int'(flags_o[0]), 0);
        pin_i = 1'b0;
        step(2);
        c = int'(count_o);
        step(1);
        check("R2 falling capture", int'(cap_o), c);

        // R2: both edges.
        do_reset(8'h03, 16'h0000, 16'h0000);
        step(3);
        pin_i = 1'b1;
        step(4);
        check("R2 both: rise", int'(flags_o[0]), 1);
        clr_i = 5'b00001;
        step(1);
        clr_i = '0;
        pin_i = 1'b0;
        step(4);
        check("R2 both: fall", int'(flags_o[0]), 1);

        // R6: counter mode counts rising pin edges only.
        do_reset(8'h05, 16'h0000, 16'h0000);
        for (int i = 0; i < 5; i++) begin
            pin_i = 1'b1; step(3);
            pin_i = 1'b0; step(3);
        end
        step(10);
        check("R6 counted edges", int'(count_o), 5);

        // R6: counter mode with no edge selected is frozen.
        do_reset(8'h04, 16'h0000, 16'h0000);
        for (int i = 0; i < 3; i++) begin
            pin_i = 1'b1; step(3);
            pin_i = 1'b0; step(3);
        end
        check("R6 disabled", int'(count_o), 0);

        // R7: split, upper counts pin edges, lower counts ticks.
        do_reset(8'h0D, 16'h0000, 16'h0000);
        for (int i = 0; i < 4; i++) begin
            pin_i = 1'b1; step(3);
            pin_i = 1'b0; step(3);
        end
        step(4);
        check("R7 split counter", int'(count_o), 16'h041B);

        // R9: alternate clock rising edges are the tick source.
        do_reset(8'h80, 16'h0000, 16'h0000);
        step(4);
        check("R9 no alt edge", int'(count_o), 0);
        alt_clk_i = 1'b1;
        step(6);
        check("R9 one alt edge", int'(count_o), 1);
        step(6);
        check("R9 alt high held", int'(count_o), 1);
        alt_clk_i = 1'b0;
        step(6);
        alt_clk_i = 1'b1;
        step(6);
        check("R9 second alt edge", int'(count_o), 2);

        // R10/R8: configuration change restarts the prescaler.
        do_reset(8'h20, 16'h0000, 16'h0000);
        step(10);
        c = int'(count_o);
        check("R8 divide by 4", c, 2);
        cfg_i = 8'h30;
        step(8);
        check("R10 no early tick", int'(count_o), c);
        step(1);
        check("R10 full period tick", int'(count_o), c + 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule